// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This unit splits every CAN bit into time quanta and tells the surrounding controller two things. It says when the receive line has been sampled and what the resolved bit is. It also says when the bit boundary has been reached, so the next transmit bit can be launched. An external prescaler supplies a single-cycle time-quantum tick, and the unit counts only on that tick. A bit is made of a one-quantum synchronization segment, a programmable segment before the sample point and a programmable segment after it.

An 8-bit timing register holds both segment lengths and the sampling mode. Software writes it through a write strobe, and a write takes effect only while the configuration-enable input is high. In single-sample mode the line is read once, in the last quantum before the sample point. In three-sample mode the first segment grows by two quanta, and the unit takes the majority of the line over its last three quanta. The decoder clamps out-of-range values, so a bit never lasts fewer than 8 quanta. While the bus is idle, a falling edge on the receive line restarts the bit at the synchronization segment (hard synchronization).

Top module: `can_bit_timer`

## Requirements
- R1: The timing register layout is bit 7 = sampling mode (0 single, 1 triple), bits 6:4 = segment-2 value, bits 3:0 = segment-1 value. A write with `cfg_we_i` high is stored only when `cfg_en_i` is high; otherwise the register, and with it the bit timing, is unchanged.
- R2: After reset the register is zero. While both segment fields are zero the unit is halted: no strobes are produced and hard synchronization is ignored.
- R3: A bit is 1 sync quantum, then segment 1 of (seg1 value + 1) quanta, then segment 2 of (seg2 value + 1) quanta. `tx_point_o` pulses in the last quantum of segment 2, and the next bit starts with a sync quantum. Counted in ticks after a hard sync, `sample_valid_o` comes at tick L1 and `tx_point_o` at tick L1+L2, where L1 and L2 are the segment lengths in quanta.
- R4: In single-sample mode `sample_valid_o` pulses once per bit, in the last quantum of segment 1, and `sample_o` then equals `rx_i` of that quantum.
- R5: In three-sample mode segment 1 is 2 quanta longer, and `sample_o` at `sample_valid_o` is the majority of `rx_i` over the last three quanta of segment 1.
- R6: Decoded values are clamped. Segment 1 is raised to at least 2 and segment 2 to at least 1. If their sum is then below 5, segment 1 is raised until the sum is 5, so a bit is never shorter than 8 quanta.
- R7: Counting advances only on `tq_tick_i`. Both strobes are one clock wide, are asserted only in a cycle with `tq_tick_i` high, and never coincide.
- R8: With `bus_idle_i` high, a change of `rx_i` from 1 (recessive) to 0 (dominant) restarts the bit at the sync segment. No strobe is produced in the cycle of that edge, even if a tick falls in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tq_tick_i | input | 1 | Time-quantum tick, one cycle wide |
| cfg_en_i | input | 1 | Configuration enable; gates register writes |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| rx_i | input | 1 | Receive line, 1 = recessive |
| bus_idle_i | input | 1 | Bus idle indication; allows hard sync |
| sample_o | output | 1 | Resolved received bit |
| sample_valid_o | output | 1 | Sample point strobe |
| tx_point_o | output | 1 | Bit boundary / transmit point strobe |

## Verification
A hard-sync edge and a time-quantum tick can fall in the same clock cycle, and the tick may be the one that would raise the sample strobe. The bench forces this by driving the receive line recessive and then dominant exactly in the sample quantum while the bus is idle. It then expects no sample strobe in that cycle. It also expects the next sample and transmit strobes to move to the spacing of a freshly started bit, with no transmit strobe at the position the old bit would have given it.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {PH_SYNC, PH_SEG1, PH_SEG2} phase_e;

  typedef struct packed {
    logic       triple;
    logic [2:0] seg2;
    logic [3:0] seg1;
  } bt_reg_t;

  localparam int SEG1_MIN = 2;
  localparam int SEG2_MIN = 1;
  localparam int SUM_MIN  = 5;
  localparam int EXTRA_TQ = 2;
  localparam int VOTES    = 3;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic             run_o,
  output logic             triple_o,
  output logic [CNT_W-1:0] seg1_len_o,
  output logic [CNT_W-1:0] seg2_len_o
);
  bt_reg_t reg_q;
  int      p1, p2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else if (cfg_we_i && cfg_en_i) reg_q <= bt_reg_t'(cfg_wdata_i);
  end

  // clamp to the legal range, then enforce the minimum bit length
  always_comb begin
    p1 = int'(reg_q.seg1);
    p2 = int'(reg_q.seg2);
    if (p1 < SEG1_MIN) p1 = SEG1_MIN;
    if (p2 < SEG2_MIN) p2 = SEG2_MIN;
    if (p1 + p2 < SUM_MIN) p1 = SUM_MIN - p2;
  end

  assign run_o      = (reg_q.seg1 != '0) || (reg_q.seg2 != '0);
  assign triple_o   = reg_q.triple;
  assign seg1_len_o = CNT_W'(p1 + 1 + (reg_q.triple ? EXTRA_TQ : 0));
  assign seg2_len_o = CNT_W'(p2 + 1);

  // R1
  p_locked_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_en_i) |=> $stable(reg_q));
  // R6
  p_min_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (32'(seg1_len_o) + 32'(seg2_len_o) + 1 >= 8));
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int NVOTE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tq_tick_i,
  input  logic             run_i,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic             triple_i,
  input  logic [CNT_W-1:0] seg1_len_i,
  input  logic [CNT_W-1:0] seg2_len_i,
  output logic             win_o,
  output logic             last_o,
  output logic             tx_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rx_q;
  logic             hsync, step;
  logic [CNT_W-1:0] win_start;
  logic             seg1_end, seg2_end;

  assign hsync     = run_i && bus_idle_i && rx_q && !rx_i;
  assign step      = run_i && tq_tick_i && !hsync;
  assign win_start = seg1_len_i - CNT_W'(triple_i ? NVOTE : 1);
  assign seg1_end  = cnt_q >= seg1_len_i - CNT_W'(1);
  assign seg2_end  = cnt_q >= seg2_len_i - CNT_W'(1);

  assign win_o  = step && (phase_q == PH_SEG1) && (cnt_q >= win_start);
  assign last_o = step && (phase_q == PH_SEG1) && seg1_end;
  assign tx_o   = step && (phase_q == PH_SEG2) && seg2_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (!run_i || hsync) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (tq_tick_i) begin
      unique case (phase_q)
        PH_SYNC: begin
          phase_q <= PH_SEG1;
          cnt_q   <= '0;
        end
        PH_SEG1: begin
          if (seg1_end) begin
            phase_q <= PH_SEG2;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        PH_SEG2: begin
          if (seg2_end) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: begin
          phase_q <= PH_SYNC;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  // R3
  p_sync_after_tx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_o |=> (phase_q == PH_SYNC));
  // R4
  p_seg2_after_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (phase_q == PH_SEG2 || !run_i));
  // R2
  p_halt_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!last_o && !tx_o && !win_o));
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler #(
  parameter int NVOTE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_i,
  input  logic triple_i,
  input  logic rx_i,
  output logic bit_o
);
  logic maj;

  generate
    if (NVOTE > 1) begin : g_vote
      logic [NVOTE-2:0] hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '1;
        else if (win_i) begin
          hist_q[0] <= rx_i;
          for (int i = 1; i < NVOTE - 1; i++) hist_q[i] <= hist_q[i-1];
        end
      end
      assign maj = $countones({hist_q, rx_i}) > (NVOTE / 2);
    end else begin : g_single
      assign maj = rx_i;
    end
  endgenerate

  assign bit_o = triple_i ? maj : rx_i;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tq_tick_i,
  input  logic       cfg_en_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       rx_i,
  input  logic       bus_idle_i,
  output logic       sample_o,
  output logic       sample_valid_o,
  output logic       tx_point_o
);
  localparam int SEG1_MAXLEN = (1 << SEG1_W) + EXTRA_TQ;
  localparam int CNT_W       = $clog2(SEG1_MAXLEN + 1);

  logic             run, triple, win, last, tx;
  logic [CNT_W-1:0] seg1_len, seg2_len;

  can_bt_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_we_i, .cfg_wdata_i,
    .run_o(run), .triple_o(triple), .seg1_len_o(seg1_len), .seg2_len_o(seg2_len)
  );

  can_bt_seq #(.CNT_W(CNT_W), .NVOTE(VOTES)) u_seq (
    .clk_i, .rst_ni, .tq_tick_i, .run_i(run), .rx_i, .bus_idle_i,
    .triple_i(triple), .seg1_len_i(seg1_len), .seg2_len_i(seg2_len),
    .win_o(win), .last_o(last), .tx_o(tx)
  );

  can_bt_sampler #(.NVOTE(VOTES)) u_smp (
    .clk_i, .rst_ni, .win_i(win), .triple_i(triple), .rx_i, .bit_o(sample_o)
  );

  assign sample_valid_o = last;
  assign tx_point_o     = tx;

  // R7
  p_strobe_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o || tx_point_o) |-> tq_tick_i);
  // R7
  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_valid_o && tx_point_o));
endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tq_tick_i = 1'b0;
  logic       cfg_en_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic       rx_i = 1'b1;
  logic       bus_idle_i = 1'b1;
  logic       sample_o, sample_valid_o, tx_point_o;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;
  logic sparse = 1'b0;
  int div = 0;

  can_bit_timer u_can_bit_timer (.*);

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (sparse) begin
      div       <= (div == 2) ? 0 : div + 1;
      tq_tick_i <= (div == 2);
    end else tq_tick_i <= 1'b1;
  end

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] v;
    logic [7:0] t;
    logic [2:0] pat;
    logic       eb;
  } vec_t;

  // cfg, sample tick, tx tick, rx pattern (L1-2, L1-1, L1), expected bit
  localparam vec_t VECS [7] = '{
    '{8'h23, 8'd4,  8'd7,  3'b110, 1'b0},  // R3 R4 single
    '{8'hA3, 8'd6,  8'd9,  3'b110, 1'b1},  // R5 triple
    '{8'h7F, 8'd16, 8'd24, 3'b001, 1'b1},  // R3 longest single
    '{8'h11, 8'd5,  8'd7,  3'b010, 1'b0},  // R6 sum clamp
    '{8'h0F, 8'd16, 8'd18, 3'b101, 1'b1},  // R6 seg2 zero
    '{8'hB2, 8'd5,  8'd9,  3'b001, 1'b0},  // R5 minority high
    '{8'h9F, 8'd18, 8'd20, 3'b101, 1'b1}   // R5 R6 longest triple
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic en, input logic [7:0] d);
    @(negedge clk_i);
    cfg_en_i = en; cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_en_i = 1'b0;
  endtask

  // recessive, then dominant at the next negedge: hard sync at the following posedge
  task automatic sync_edge();
    @(negedge clk_i); bus_idle_i = 1'b1; rx_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rx_i = 1'b0;
  endtask

  task automatic measure(input int v, input logic [2:0] pat,
                         output int fv, output int ft, output int sv, output int bitv);
    fv = -1; ft = -1; sv = -1; bitv = -1;
    for (int m = 0; m < 60; m++) begin
      @(negedge clk_i);
      bus_idle_i = 1'b0;
      rx_i = (m == v - 2) ? pat[2] : (m == v - 1) ? pat[1] : (m == v) ? pat[0] : 1'b0;
      #1;
      if (sample_valid_o) begin
        if (fv < 0) begin fv = m; bitv = int'(sample_o); end
        else if (sv < 0) sv = m;
      end
      if (tx_point_o && ft < 0) ft = m;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int fv, ft, sv, bv, cnt, last_tx, gap, bad;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: reset state halted, hard sync ignored
    cnt = 0;
    sync_edge();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i); #1;
      if (sample_valid_o || tx_point_o) cnt++;
    end
    chk("R2 strobes after reset", cnt, 0);

    // table walk: R3 R4 R5 R6
    foreach (VECS[k]) begin
      write_cfg(1'b1, VECS[k].cfg);
      sync_edge();
      measure(int'(VECS[k].v), VECS[k].pat, fv, ft, sv, bv);
      chk($sformatf("R3 sample tick vec%0d", k), fv, int'(VECS[k].v));
      chk($sformatf("R3 tx tick vec%0d", k), ft, int'(VECS[k].t));
      chk($sformatf("R3 next bit sample vec%0d", k), sv, int'(VECS[k].t) + 1 + int'(VECS[k].v));
      chk($sformatf("R4 R5 resolved bit vec%0d", k), bv, int'(VECS[k].eb));
    end

    // R1: write with enable low is ignored
    write_cfg(1'b1, 8'h23);
    write_cfg(1'b0, 8'h7F);
    sync_edge();
    measure(4, 3'b000, fv, ft, sv, bv);
    chk("R1 locked write sample tick", fv, 4);
    chk("R1 locked write tx tick", ft, 7);

    // R2: both segment fields zero halts the unit
    write_cfg(1'b1, 8'h80);
    sync_edge();
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); #1;
      if (sample_valid_o || tx_point_o) cnt++;
    end
    chk("R2 zero fields halt", cnt, 0);

    // R8: hard sync in the sample quantum
    write_cfg(1'b1, 8'h23);
    sync_edge();
    fv = -1; ft = -1; cnt = 0;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk_i);
      bus_idle_i = 1'b1;
      rx_i = (m == 3) ? 1'b1 : 1'b0;
      #1;
      if (m == 4) chk("R8 no strobe in sync cycle", int'(sample_valid_o), 0);
      if (m == 7) chk("R8 old tx point gone", int'(tx_point_o), 0);
      if (sample_valid_o && fv < 0) fv = m;
      if (tx_point_o && ft < 0) ft = m;
    end
    chk("R8 restarted sample tick", fv, 9);
    chk("R8 restarted tx tick", ft, 12);

    // R7: sparse ticks, one tick every 3 clocks
    bus_idle_i = 1'b0;
    sparse = 1'b1;
    last_tx = -1; gap = -1; bad = 0; cnt = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk_i); #1;
      if ((sample_valid_o || tx_point_o) && !tq_tick_i) bad++;
      if (sample_valid_o) cnt++;
      if (tx_point_o) begin
        if (last_tx >= 0) gap = i - last_tx;
        last_tx = i;
      end
    end
    sparse = 1'b0;
    chk("R7 strobe without tick", bad, 0);
    chk("R7 bit period in clocks", gap, 24);
    chk("R7 sample strobes per 5 bits", cnt, 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule